// File: doc/BRIEF.md
# Firmware Hub Bus Target

This block is the target side of a 4-bit multiplexed firmware-hub bus. Every field on the bus lasts exactly one clock. The host frames a cycle by pulling `frame_n` low together with a start code. It then sends a device-select nibble, seven address nibbles with the most significant first, and a size nibble. A write cycle also carries two data nibbles. The target checks the device-select nibble against its strapped `dev_id` and checks the size nibble. Once both checks pass, it runs the rest of the cycle without any further checks.

For a write, the target presents the 28-bit address and the assembled byte with a one-clock `wr_stb`. For a read, it raises `rd_stb` with the address and takes the byte from `rd_data`. It then answers on the bus: a sync nibble, the data nibbles (read only), a driven 1111 turnaround nibble, and one floated clock.

If `frame_n` goes low in the middle of a cycle, the target drops the cycle. It then ignores the bus until the host sends the all-ones abort nibble. The bidirectional nibble bus is split into `nib_in`, `nib_out` and the output enable `nib_oe`.

Top module: `fwh_target`

## Requirements
- R1: A cycle starts only while `frame_n` is low and `nib_in` carries a start code: 1110 selects a write and 1101 selects a read. While `frame_n` stays low, the most recent start code decides the cycle type. Any other nibble seen while `frame_n` is low cancels the pending start.
- R2: The first nibble after `frame_n` rises must equal `dev_id`. On a mismatch the target returns to idle, raises no strobe and does not drive the bus for the rest of that cycle.
- R3: The seven address nibbles are shifted in most significant first into `acc_addr[27:0]`. `acc_reg_sel` is bit 22 of that address (1 = register space, 0 = core), and `acc_offs` is bits 19:0.
- R4: A size nibble other than 0000 sends the target back to idle. It then raises no strobe and never drives the bus for that cycle.
- R5: For a write, the first data nibble is `wr_data[3:0]` and the second is `wr_data[7:4]`. `wr_stb` is high for exactly one clock, during the field that follows the second data nibble, and `acc_addr` is valid in that clock.
- R6: For a write, after two host turnaround clocks the target drives 0000 (sync) for one field. It then drives 1111 for one field and releases the bus for one field before returning to idle.
- R7: For a read, `rd_stb` is high for one clock, in the field after the size nibble. `rd_data` is sampled at the clock edge that ends the sync field. After two host turnaround clocks the target drives 0000, then `rd_data[3:0]`, then `rd_data[7:4]`, then 1111, and then releases the bus for one field.
- R8: `frame_n` low in any field after the device-select field ends the cycle: on the next clock there is no bus drive and no strobe. Every nibble except 1111 is then ignored, including start codes. A 1111 nibble returns the target to idle.
- R9: After the start, device-select and size fields have been accepted, the contents of the host turnaround fields are not checked.
- R10: `nib_oe` is high only in the sync, read-data and driven-turnaround fields. Every rise of `nib_oe` begins with `nib_out` = 0000.
- R11: A synchronous active-high `rst` returns the target to idle with `nib_oe`, `wr_stb` and `rd_stb` low on the next clock, even in the middle of a cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_n | input | 1 | Cycle framing, active low |
| nib_in | input | 4 | Nibble sampled from the bus |
| dev_id | input | 4 | Strapped device select value |
| nib_out | output | 4 | Nibble driven onto the bus |
| nib_oe | output | 1 | Bus drive enable for `nib_out` |
| acc_addr | output | 28 | Assembled cycle address |
| acc_reg_sel | output | 1 | Register space (1) or core (0) select |
| acc_offs | output | 20 | Decoded memory offset |
| wr_stb | output | 1 | One-clock write strobe |
| wr_data | output | 8 | Assembled write byte |
| rd_stb | output | 1 | One-clock read request |
| rd_data | input | 8 | Read byte returned by the backend |

## Verification
The assertions assume that the host pulls `frame_n` low during a target-driven field only to abort, and that the reset is synchronous. The read backend must hold `rd_data` steady from the clock after `rd_stb` until the sync field ends, and `dev_id` must stay static. The bench drives every bus input on the falling clock edge and keeps `dev_id` fixed. Its backend model loads `rd_data` only on the edge where it sees `rd_stb`, so the byte stays stable through the sync field.

// File: rtl/fwh_pkg.sv
package fwh_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_START,
    S_ADDR,
    S_SIZE,
    S_WDATA,
    S_HTAR0,
    S_HTAR1,
    S_SYNC,
    S_RDATA,
    S_TTAR0,
    S_TTAR1,
    S_ABORT
  } fwh_state_e;
endpackage

// File: rtl/fwh_seq.sv
module fwh_seq
  import fwh_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int ADDR_NIBS = 7,
  parameter int DATA_NIBS = 2,
  parameter int CNT_W = 3,
  parameter logic [NIB_W-1:0] START_WR = 4'b1110,
  parameter logic [NIB_W-1:0] START_RD = 4'b1101,
  parameter logic [NIB_W-1:0] SIZE_ONE = 4'b0000,
  parameter logic [NIB_W-1:0] ABORT_CODE = 4'b1111
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_n,
  input  logic [NIB_W-1:0] nib_in,
  input  logic [NIB_W-1:0] dev_id,
  output fwh_state_e       state,
  output fwh_state_e       nstate,
  output logic [CNT_W-1:0] cnt,
  output logic             wr_stb,
  output logic             rd_stb
);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIBS - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_NIBS - 1);

  logic             is_rd, is_rd_n;
  logic [CNT_W-1:0] cnt_n;
  logic             in_cycle;
  logic             start_hit;

  assign in_cycle  = !(state inside {S_IDLE, S_START, S_ABORT});
  assign start_hit = (nib_in == START_WR) || (nib_in == START_RD);

  always_comb begin
    nstate  = state;
    cnt_n   = cnt;
    is_rd_n = is_rd;
    if (in_cycle && !frame_n) begin
      nstate = S_ABORT;
    end else begin
      case (state)
        S_IDLE: begin
          if (!frame_n && start_hit) begin
            nstate  = S_START;
            is_rd_n = (nib_in == START_RD);
          end
        end
        S_START: begin
          if (!frame_n) begin
            if (start_hit) is_rd_n = (nib_in == START_RD);
            else           nstate  = S_IDLE;
          end else if (nib_in == dev_id) begin
            nstate = S_ADDR;
            cnt_n  = '0;
          end else begin
            nstate = S_IDLE;
          end
        end
        S_ADDR: begin
          if (cnt == ADDR_LAST) nstate = S_SIZE;
          else                  cnt_n  = cnt + 1'b1;
        end
        S_SIZE: begin
          if (nib_in != SIZE_ONE) nstate = S_IDLE;
          else if (is_rd)         nstate = S_HTAR0;
          else begin
            nstate = S_WDATA;
            cnt_n  = '0;
          end
        end
        S_WDATA: begin
          if (cnt == DATA_LAST) nstate = S_HTAR0;
          else                  cnt_n  = cnt + 1'b1;
        end
        S_HTAR0: nstate = S_HTAR1;
        S_HTAR1: nstate = S_SYNC;
        S_SYNC: begin
          if (is_rd) begin
            nstate = S_RDATA;
            cnt_n  = '0;
          end else begin
            nstate = S_TTAR0;
          end
        end
        S_RDATA: begin
          if (cnt == DATA_LAST) nstate = S_TTAR0;
          else                  cnt_n  = cnt + 1'b1;
        end
        S_TTAR0: nstate = S_TTAR1;
        S_TTAR1: nstate = S_IDLE;
        S_ABORT: if (nib_in == ABORT_CODE) nstate = S_IDLE;
        default: nstate = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      cnt    <= '0;
      is_rd  <= 1'b0;
      wr_stb <= 1'b0;
      rd_stb <= 1'b0;
    end else begin
      state  <= nstate;
      cnt    <= cnt_n;
      is_rd  <= is_rd_n;
      wr_stb <= (state == S_WDATA) && (nstate == S_HTAR0);
      rd_stb <= (state == S_SIZE) && (nstate == S_HTAR0);
    end
  end
endmodule

// File: rtl/fwh_capture.sv
module fwh_capture
  import fwh_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int ADDR_NIBS = 7,
  parameter int DATA_NIBS = 2,
  parameter int CNT_W = 3,
  localparam int ADDR_W = NIB_W * ADDR_NIBS,
  localparam int DATA_W = NIB_W * DATA_NIBS
) (
  input  logic              clk,
  input  logic              rst,
  input  fwh_state_e        state,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [NIB_W-1:0]  nib_in,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst)                  addr <= '0;
    else if (state == S_ADDR) addr <= {addr[ADDR_W-NIB_W-1:0], nib_in};
  end

  logic [NIB_W-1:0] dnib [DATA_NIBS];

  for (genvar g = 0; g < DATA_NIBS; g++) begin : g_dnib
    always_ff @(posedge clk) begin
      if (rst)                                             dnib[g] <= '0;
      else if (state == S_WDATA && cnt == CNT_W'(g))       dnib[g] <= nib_in;
    end
    assign data[g*NIB_W +: NIB_W] = dnib[g];
  end
endmodule

// File: rtl/fwh_drive.sv
module fwh_drive
  import fwh_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int DATA_W = 8,
  parameter logic [NIB_W-1:0] SYNC_CODE = 4'b0000,
  parameter logic [NIB_W-1:0] TAR_CODE = 4'b1111
) (
  input  logic              clk,
  input  logic              rst,
  input  fwh_state_e        state,
  input  fwh_state_e        nstate,
  input  logic [DATA_W-1:0] rd_data,
  output logic [NIB_W-1:0]  nib_out,
  output logic              nib_oe
);
  logic [DATA_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      nib_oe  <= 1'b0;
      nib_out <= TAR_CODE;
      sh      <= '0;
    end else begin
      nib_oe <= nstate inside {S_SYNC, S_RDATA, S_TTAR0};
      case (nstate)
        S_SYNC:  nib_out <= SYNC_CODE;
        S_RDATA: begin
          if (state == S_SYNC) begin
            nib_out <= rd_data[NIB_W-1:0];
            sh      <= rd_data >> NIB_W;
          end else begin
            nib_out <= sh[NIB_W-1:0];
            sh      <= sh >> NIB_W;
          end
        end
        default: nib_out <= TAR_CODE;
      endcase
    end
  end
endmodule

// File: rtl/fwh_target.sv
module fwh_target
  import fwh_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int ADDR_NIBS = 7,
  parameter int DATA_NIBS = 2,
  parameter int MEM_W = 20,
  parameter int REG_BIT = 22,
  parameter logic [NIB_W-1:0] START_WR = 4'b1110,
  parameter logic [NIB_W-1:0] START_RD = 4'b1101,
  localparam int ADDR_W = NIB_W * ADDR_NIBS,
  localparam int DATA_W = NIB_W * DATA_NIBS,
  localparam int CNT_W = $clog2(ADDR_NIBS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n,
  input  logic [NIB_W-1:0]  nib_in,
  input  logic [NIB_W-1:0]  dev_id,
  output logic [NIB_W-1:0]  nib_out,
  output logic              nib_oe,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              acc_reg_sel,
  output logic [MEM_W-1:0]  acc_offs,
  output logic              wr_stb,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_stb,
  input  logic [DATA_W-1:0] rd_data
);
  fwh_state_e       state, nstate;
  logic [CNT_W-1:0] cnt;

  fwh_seq #(
    .NIB_W(NIB_W), .ADDR_NIBS(ADDR_NIBS), .DATA_NIBS(DATA_NIBS), .CNT_W(CNT_W),
    .START_WR(START_WR), .START_RD(START_RD),
    .SIZE_ONE({NIB_W{1'b0}}), .ABORT_CODE({NIB_W{1'b1}})
  ) u_seq (
    .clk(clk), .rst(rst), .frame_n(frame_n), .nib_in(nib_in), .dev_id(dev_id),
    .state(state), .nstate(nstate), .cnt(cnt), .wr_stb(wr_stb), .rd_stb(rd_stb)
  );

  fwh_capture #(
    .NIB_W(NIB_W), .ADDR_NIBS(ADDR_NIBS), .DATA_NIBS(DATA_NIBS), .CNT_W(CNT_W)
  ) u_cap (
    .clk(clk), .rst(rst), .state(state), .cnt(cnt), .nib_in(nib_in),
    .addr(acc_addr), .data(wr_data)
  );

  fwh_drive #(
    .NIB_W(NIB_W), .DATA_W(DATA_W),
    .SYNC_CODE({NIB_W{1'b0}}), .TAR_CODE({NIB_W{1'b1}})
  ) u_drv (
    .clk(clk), .rst(rst), .state(state), .nstate(nstate), .rd_data(rd_data),
    .nib_out(nib_out), .nib_oe(nib_oe)
  );

  assign acc_reg_sel = acc_addr[REG_BIT];
  assign acc_offs    = acc_addr[MEM_W-1:0];
endmodule

// File: rtl/fwh_target_chk.sv
module fwh_target_chk #(
  parameter int NIB_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_n,
  input logic [NIB_W-1:0] nib_out,
  input logic             nib_oe,
  input logic             wr_stb,
  input logic             rd_stb
);
  p_reset_quiet_r11: assert property (@(posedge clk)
    rst |=> (!nib_oe && !wr_stb && !rd_stb));

  p_wr_single_r5: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  p_rd_single_r7: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> !rd_stb);

  p_rd_no_drive_r7: assert property (@(posedge clk) disable iff (rst)
    rd_stb |-> !nib_oe);

  p_frame_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !frame_n |=> (!nib_oe && !wr_stb && !rd_stb));

  p_sync_first_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(nib_oe) |-> (nib_out == '0));

  p_release_after_tar_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(nib_oe) && $past(frame_n) && !$past(rst)) |-> ($past(nib_out) == '1));
endmodule

bind fwh_target fwh_target_chk #(.NIB_W(NIB_W)) u_chk (
  .clk(clk), .rst(rst), .frame_n(frame_n), .nib_out(nib_out),
  .nib_oe(nib_oe), .wr_stb(wr_stb), .rd_stb(rd_stb)
);

// File: tb/sim_fwh_target.sv
module sim_fwh_target;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] MY_ID = 4'h5;
  localparam logic [3:0] C_WR = 4'b1110;
  localparam logic [3:0] C_RD = 4'b1101;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_n = 1'b1;
  logic [3:0]  nib_in = 4'hF;
  logic [3:0]  dev_id = MY_ID;
  logic [3:0]  nib_out;
  logic        nib_oe;
  logic [27:0] acc_addr;
  logic        acc_reg_sel;
  logic [19:0] acc_offs;
  logic        wr_stb;
  logic [7:0]  wr_data;
  logic        rd_stb;
  logic [7:0]  rd_data = 8'h00;

  int vectors = 0;
  int fails = 0;
  int wr_seen = 0;
  int rd_seen = 0;
  int oe_seen = 0;

  fwh_target u0 (
    .clk(clk), .rst(rst), .frame_n(frame_n), .nib_in(nib_in), .dev_id(dev_id),
    .nib_out(nib_out), .nib_oe(nib_oe), .acc_addr(acc_addr),
    .acc_reg_sel(acc_reg_sel), .acc_offs(acc_offs), .wr_stb(wr_stb),
    .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (rd_stb) rd_data <= acc_addr[7:0] ^ 8'h5A;

  always @(negedge clk) begin
    if (wr_stb) wr_seen++;
    if (rd_stb) rd_seen++;
    if (nib_oe) oe_seen++;
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic fr, input logic [3:0] n);
    @(negedge clk);
    frame_n = fr;
    nib_in  = n;
    @(posedge clk);
    #1;
  endtask

  task automatic hdr(input logic [3:0] sc, input logic [3:0] id,
                     input logic [27:0] a, input logic [3:0] sz);
    step(1'b0, sc);
    step(1'b1, id);
    for (int i = 6; i >= 0; i--) step(1'b1, a[i*4 +: 4]);
    step(1'b1, sz);
  endtask

  task automatic do_write(input logic [27:0] a, input logic [7:0] d,
                          input logic [3:0] tar);
    hdr(C_WR, MY_ID, a, 4'h0);
    step(1'b1, d[3:0]);
    step(1'b1, d[7:4]);
    chk("R5", "wr_stb", wr_stb, 1);
    chk("R5", "wr_data", wr_data, d);
    chk("R3", "acc_addr", acc_addr, a);
    chk("R3", "acc_reg_sel", acc_reg_sel, a[22]);
    chk("R3", "acc_offs", acc_offs, a[19:0]);
    chk("R10", "oe in host tar", nib_oe, 0);
    step(1'b1, tar);
    chk("R5", "wr_stb single", wr_stb, 0);
    chk("R9", "oe host tar1", nib_oe, 0);
    step(1'b1, 4'hF);
    chk("R6", "sync oe", nib_oe, 1);
    chk("R6", "sync nibble", nib_out, 4'h0);
    step(1'b1, 4'hF);
    chk("R6", "tar oe", nib_oe, 1);
    chk("R6", "tar nibble", nib_out, 4'hF);
    step(1'b1, 4'hF);
    chk("R6", "release", nib_oe, 0);
    step(1'b1, 4'hF);
    chk("R10", "idle oe", nib_oe, 0);
  endtask

  task automatic do_read(input int pre, input logic [27:0] a);
    logic [7:0] exp_d;
    exp_d = a[7:0] ^ 8'h5A;
    for (int i = 0; i < pre; i++) step(1'b0, C_WR);
    hdr(C_RD, MY_ID, a, 4'h0);
    chk("R7", "rd_stb", rd_stb, 1);
    chk("R3", "rd acc_addr", acc_addr, a);
    chk("R3", "rd acc_reg_sel", acc_reg_sel, a[22]);
    chk("R7", "oe with rd_stb", nib_oe, 0);
    step(1'b1, 4'hF);
    chk("R7", "rd_stb single", rd_stb, 0);
    chk("R10", "oe host tar1", nib_oe, 0);
    step(1'b1, 4'hF);
    chk("R7", "sync", {nib_oe, nib_out}, {1'b1, 4'h0});
    step(1'b1, 4'hF);
    chk("R7", "low data nibble", {nib_oe, nib_out}, {1'b1, exp_d[3:0]});
    step(1'b1, 4'hF);
    chk("R7", "high data nibble", {nib_oe, nib_out}, {1'b1, exp_d[7:4]});
    step(1'b1, 4'hF);
    chk("R7", "tar nibble", {nib_oe, nib_out}, {1'b1, 4'hF});
    step(1'b1, 4'hF);
    chk("R7", "release", nib_oe, 0);
    step(1'b1, 4'hF);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "oe in reset", nib_oe, 0);
    chk("R11", "strobes in reset", {wr_stb, rd_stb}, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_id_mismatch();
    int w0, o0;
    w0 = wr_seen;
    o0 = oe_seen;
    hdr(C_WR, MY_ID ^ 4'h1, 28'h0123456, 4'h0);
    step(1'b1, 4'h7);
    step(1'b1, 4'h8);
    repeat (5) step(1'b1, 4'hF);
    chk("R2", "no wr strobe", wr_seen - w0, 0);
    chk("R2", "no drive", oe_seen - o0, 0);
    do_write(28'h3A07E19, 8'hC3, 4'hF);
  endtask

  task automatic t_bad_size();
    int w0, o0;
    w0 = wr_seen;
    o0 = oe_seen;
    hdr(C_WR, MY_ID, 28'h0456789, 4'h2);
    step(1'b1, 4'h1);
    step(1'b1, 4'h2);
    repeat (5) step(1'b1, 4'hF);
    chk("R4", "no wr strobe", wr_seen - w0, 0);
    chk("R4", "no drive", oe_seen - o0, 0);
    do_read(0, 28'h1B4C0D2);
  endtask

  task automatic t_multi_start();
    int w0, r0;
    w0 = wr_seen;
    r0 = rd_seen;
    do_read(2, 28'h0FFB0100);
    chk("R1", "last start selects read", rd_seen - r0, 1);
    chk("R1", "no write from earlier start", wr_seen - w0, 0);
  endtask

  task automatic t_abort();
    int w0, o0;
    w0 = wr_seen;
    o0 = oe_seen;
    step(1'b0, C_WR);
    step(1'b1, MY_ID);
    step(1'b1, 4'h1);
    step(1'b1, 4'h2);
    step(1'b0, 4'h0);
    hdr(C_WR, MY_ID, 28'h1234567, 4'h0);
    step(1'b1, 4'h5);
    step(1'b1, 4'h6);
    step(1'b1, 4'h0);
    step(1'b1, 4'h0);
    chk("R8", "ignored until abort nibble, strobes", wr_seen - w0, 0);
    chk("R8", "ignored until abort nibble, drive", oe_seen - o0, 0);
    step(1'b1, 4'hF);
    do_write(28'h0C52A31, 8'h96, 4'hF);
  endtask

  task automatic t_abort_sync();
    hdr(C_RD, MY_ID, 28'h0000010, 4'h0);
    step(1'b1, 4'hF);
    step(1'b1, 4'hF);
    chk("R8", "sync before abort", nib_oe, 1);
    step(1'b0, 4'h3);
    chk("R8", "drive dropped on abort", nib_oe, 0);
    step(1'b1, 4'hF);
    chk("R8", "idle after abort nibble", nib_oe, 0);
  endtask

  task automatic t_reset_mid();
    hdr(C_WR, MY_ID, 28'h0222222, 4'h0);
    step(1'b1, 4'h4);
    step(1'b1, 4'h4);
    step(1'b1, 4'hF);
    step(1'b1, 4'hF);
    chk("R6", "sync before reset", nib_oe, 1);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R11", "oe after mid reset", nib_oe, 0);
    @(negedge clk);
    rst = 1'b0;
    do_read(0, 28'h0400033);
  endtask

  initial begin
    t_reset();
    do_write(28'h3A07E19, 8'h3C, 4'hF);
    do_write(28'h0C52A31, 8'hA5, 4'hF);
    do_read(0, 28'h1B4C0D2);
    do_read(0, 28'h0400077);
    t_multi_start();
    t_id_mismatch();
    t_bad_size();
    t_abort();
    t_abort_sync();
    do_write(28'h0010203, 8'h7E, 4'h0);
    t_reset_mid();
    summary();
  end
endmodule